// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit Transfer Engine

This block moves one data unit each time one of its eight channels is triggered. Each channel picks its trigger from 48 start sources: one software start line and 47 interrupt request lines. A trigger is latched as a pending flag for its source. The engine serves the lowest-numbered channel whose source is pending. For that channel it reads one unit from the source address and then writes it to the destination address over a simple request/ready memory bus. It then steps both addresses and decrements the channel's 16-bit transfer counter.

When the counter reaches zero, the engine pulses that channel's terminal-count output so the interrupt can be handed on to the processor. The channel then stops responding to triggers. Writing its counter again re-arms it. A count-only mode updates addresses and counter without touching the bus. Software programs each channel through a small register port: source, destination, counter, mode and start-source select.

Top module: `udma_engine`

## Requirements
- R1: When several channels have a pending trigger in the same cycle, the lowest channel number is served first. The next is served only after the first finishes its read and write.
- R2: When two enabled channels select the same start source, one trigger serves only the lower-numbered channel. Serving it clears the pending flag, so the other channel's counter stays unchanged.
- R3: Address registers hold 32 bits, but `bus_addr` carries only bits 23..0. Bits 31..24 are kept across every address update.
- R4: Mode bits [1:0] choose the unit size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The byte enables cover that many lanes starting at the address lane. Bit 0 of the address is ignored for 2-byte units, and bits 1..0 are ignored for 4-byte units.
- R5: Mode bits [3:2] (source) and [5:4] (destination) control the address step: 1 increments by the unit size, 2 decrements by it, and 0 or 3 holds the address. Arithmetic wraps modulo 2^24.
- R6: Each service decrements the counter by one. A counter of 0000h becomes FFFFh without terminal count, so a count of zero gives 65536 services.
- R7: The service that brings the counter to zero pulses bit n of `tc` for one cycle and disables channel n. Writing the counter register (code 2) re-enables the channel.
- R8: Start-source register value 0 selects `sw_start`, and value v (1..47) selects `int_req[v-1]`. A trigger stays pending until an enabled channel with that source is served.
- R9: A data service is one read from the source followed directly by one write to the destination. Each phase holds `bus_req`, `bus_we` and `bus_addr` steady until `bus_rdy` is high. The bytes read land at the destination lanes.
- R10: With mode bit [6] set, a service makes no bus access but still updates the addresses and the counter.
- R11: After reset, all channel registers read zero, every channel is disabled and `bus_req` and `tc` are low.
- R12: Register codes are source 0, destination 1, counter 2, mode 3 and start source 4. A write takes effect at the clock edge when `cfg_we` is high, and `cfg_rdata` shows the selected register of `cfg_ch` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 47 | Interrupt request lines, start sources 1..47 |
| sw_start | input | 1 | Software start, start source 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel selected for write and readback |
| cfg_reg | input | 3 | Register code |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | High for the write phase |
| bus_addr | output | 24 | Byte address |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Write data on byte lanes |
| bus_rdata | input | 32 | Read data on byte lanes |
| bus_rdy | input | 1 | Completes the current access at the clock edge |
| tc | output | 8 | Terminal-count pulse per channel |

## Verification
The assertions assume that software does not write a channel's registers while that channel is being served, and that `bus_rdy` is driven only in answer to `bus_req`. The assertions on address and enable updates are qualified by the absence of a register write in the same cycle. The stimulus keeps within this by programming channels only while the engine is idle, waiting long enough after every trigger for the service to finish, and answering each bus phase with ready after a fixed number of wait states. Start-source codes above 47 are never programmed.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int NCH    = 8;
    localparam int NVEC   = 48;
    localparam int CH_W   = $clog2(NCH);
    localparam int VEC_W  = $clog2(NVEC);
    localparam int AW     = 24;
    localparam int DW     = 32;
    localparam int CW     = 16;
    localparam int BE_W   = DW / 8;
    localparam int REG_W  = 3;

    localparam logic [REG_W-1:0] REG_SRC  = 3'd0;
    localparam logic [REG_W-1:0] REG_DST  = 3'd1;
    localparam logic [REG_W-1:0] REG_CNT  = 3'd2;
    localparam logic [REG_W-1:0] REG_MODE = 3'd3;
    localparam logic [REG_W-1:0] REG_VEC  = 3'd4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        AU_HOLD  = 2'd0,
        AU_INC   = 2'd1,
        AU_DEC   = 2'd2,
        AU_HOLD2 = 2'd3
    } aupd_e;

    typedef struct packed {
        logic  cnt_only;
        aupd_e dupd;
        aupd_e supd;
        size_e size;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic [DW-1:0]    src;
        logic [DW-1:0]    dst;
        logic [CW-1:0]    cnt;
        mode_t            mode;
        logic [VEC_W-1:0] vec;
        logic             en;
    } chan_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2,
        S_UPD  = 2'd3
    } seq_e;

    function automatic logic [2:0] step_of(size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] addr_next(logic [DW-1:0] a, aupd_e u, size_e s);
        logic [AW-1:0] lo;
        lo = a[AW-1:0];
        case (u)
            AU_INC:  lo = lo + AW'(step_of(s));
            AU_DEC:  lo = lo - AW'(step_of(s));
            default: lo = a[AW-1:0];
        endcase
        return {a[DW-1:AW], lo};
    endfunction

    function automatic logic [1:0] lane_off(size_e s, logic [1:0] a);
        case (s)
            SZ_BYTE: return a;
            SZ_HALF: return {a[1], 1'b0};
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [BE_W-1:0] lane_be(size_e s, logic [1:0] a);
        case (s)
            SZ_BYTE: return BE_W'(4'b0001) << a;
            SZ_HALF: return BE_W'(4'b0011) << {a[1], 1'b0};
            default: return {BE_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/udma_arbiter.sv
module udma_arbiter
    import udma_pkg::*;
(
    input  logic [NCH-1:0]  req,
    output logic [CH_W-1:0] gnt_idx,
    output logic            gnt_vld
);

    // Scan from the top down so the lowest requesting index is the last one kept.
    always_comb begin
        gnt_idx = '0;
        gnt_vld = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = CH_W'(i);
                gnt_vld = 1'b1;
            end
        end
    end

endmodule

// File: rtl/udma_pend.sv
module udma_pend
    import udma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NVEC-1:0]  set_in,
    input  logic             clr_vld,
    input  logic [VEC_W-1:0] clr_vec,
    output logic [NVEC-1:0]  pend
);

    for (genvar v = 0; v < NVEC; v++) begin : g_flag
        logic hit;
        assign hit = clr_vld && (clr_vec == VEC_W'(v));
        always_ff @(posedge clk) begin
            if (rst) pend[v] <= 1'b0;
            else     pend[v] <= set_in[v] | (pend[v] & ~hit);
        end
    end

    // R2
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !set_in[clr_vec]) |=> !pend[$past(clr_vec)]);

endmodule

// File: rtl/udma_chan_file.sv
module udma_chan_file
    import udma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [REG_W-1:0]     cfg_reg,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    input  logic                 upd_vld,
    input  logic [CH_W-1:0]      upd_ch,
    input  logic [DW-1:0]        upd_src,
    input  logic [DW-1:0]        upd_dst,
    input  logic [CW-1:0]        upd_cnt,
    input  logic                 upd_disable,
    output chan_t [NCH-1:0]      chans
);

    // Service updates first, register writes after, so software wins a collision.
    always_ff @(posedge clk) begin
        if (rst) begin
            chans <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (upd_vld && upd_ch == CH_W'(c)) begin
                    chans[c].src <= upd_src;
                    chans[c].dst <= upd_dst;
                    chans[c].cnt <= upd_cnt;
                    if (upd_disable) chans[c].en <= 1'b0;
                end
                if (cfg_we && cfg_ch == CH_W'(c)) begin
                    case (cfg_reg)
                        REG_SRC:  chans[c].src  <= cfg_wdata;
                        REG_DST:  chans[c].dst  <= cfg_wdata;
                        REG_CNT: begin
                            chans[c].cnt <= cfg_wdata[CW-1:0];
                            chans[c].en  <= 1'b1;
                        end
                        REG_MODE: chans[c].mode <= mode_t'(cfg_wdata[MODE_W-1:0]);
                        REG_VEC:  chans[c].vec  <= cfg_wdata[VEC_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (cfg_reg)
            REG_SRC:  cfg_rdata = chans[cfg_ch].src;
            REG_DST:  cfg_rdata = chans[cfg_ch].dst;
            REG_CNT:  cfg_rdata = DW'(chans[cfg_ch].cnt);
            REG_MODE: cfg_rdata = DW'(chans[cfg_ch].mode);
            REG_VEC:  cfg_rdata = DW'(chans[cfg_ch].vec);
            default:  cfg_rdata = '0;
        endcase
    end

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && !cfg_we) |=>
        (chans[$past(upd_ch)].src[DW-1:AW] == $past(chans[upd_ch].src[DW-1:AW])));

    // R7
    tc_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && upd_disable && !cfg_we) |=> !chans[$past(upd_ch)].en);

endmodule

// File: rtl/udma_xfer_seq.sv
module udma_xfer_seq
    import udma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  chan_t [NCH-1:0]      chans,
    input  logic                 gnt_vld,
    input  logic [CH_W-1:0]      gnt_idx,
    output logic                 idle,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [AW-1:0]        bus_addr,
    output logic [BE_W-1:0]      bus_be,
    output logic [DW-1:0]        bus_wdata,
    input  logic [DW-1:0]        bus_rdata,
    input  logic                 bus_rdy,
    output logic                 upd_vld,
    output logic [CH_W-1:0]      upd_ch,
    output logic [DW-1:0]        upd_src,
    output logic [DW-1:0]        upd_dst,
    output logic [CW-1:0]        upd_cnt,
    output logic                 upd_disable,
    output logic [NCH-1:0]       tc
);

    seq_e            state;
    logic [CH_W-1:0] cur;
    logic [DW-1:0]   hold;
    chan_t           cc;
    logic [AW-1:0]   a_lo;
    logic [1:0]      off;

    assign cc   = chans[cur];
    assign idle = (state == S_IDLE);

    assign a_lo = (state == S_WR) ? cc.dst[AW-1:0] : cc.src[AW-1:0];
    assign off  = lane_off(cc.mode.size, a_lo[1:0]);

    assign bus_req   = (state == S_RD) || (state == S_WR);
    assign bus_we    = (state == S_WR);
    assign bus_addr  = a_lo;
    assign bus_be    = lane_be(cc.mode.size, a_lo[1:0]);
    assign bus_wdata = hold << {off, 3'b000};

    assign upd_vld     = (state == S_UPD);
    assign upd_ch      = cur;
    assign upd_src     = addr_next(cc.src, cc.mode.supd, cc.mode.size);
    assign upd_dst     = addr_next(cc.dst, cc.mode.dupd, cc.mode.size);
    assign upd_cnt     = cc.cnt - CW'(1);
    assign upd_disable = (upd_cnt == '0);
    assign tc          = (upd_vld && upd_disable) ? (NCH'(1) << cur) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
            hold  <= '0;
        end else begin
            case (state)
                S_IDLE: if (gnt_vld) begin
                    cur   <= gnt_idx;
                    state <= chans[gnt_idx].mode.cnt_only ? S_UPD : S_RD;
                end
                S_RD: if (bus_rdy) begin
                    hold  <= bus_rdata >> {off, 3'b000};
                    state <= S_WR;
                end
                S_WR: if (bus_rdy) state <= S_UPD;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_rdy) |=> (bus_req && bus_we));

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

    // R10
    cnt_only_nobus_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && gnt_vld && chans[gnt_idx].mode.cnt_only) |=> (!bus_req && upd_vld));

    // R9
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_we);

endmodule

// File: rtl/udma_engine.sv
module udma_engine
    import udma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NVEC-2:0]      int_req,
    input  logic                 sw_start,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [REG_W-1:0]     cfg_reg,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [AW-1:0]        bus_addr,
    output logic [BE_W-1:0]      bus_be,
    output logic [DW-1:0]        bus_wdata,
    input  logic [DW-1:0]        bus_rdata,
    input  logic                 bus_rdy,
    output logic [NCH-1:0]       tc
);

    chan_t [NCH-1:0]  chans;
    logic [NVEC-1:0]  pend;
    logic [NCH-1:0]   req;
    logic [CH_W-1:0]  gnt_idx;
    logic             gnt_vld;
    logic             idle;
    logic             upd_vld;
    logic [CH_W-1:0]  upd_ch;
    logic [DW-1:0]    upd_src;
    logic [DW-1:0]    upd_dst;
    logic [CW-1:0]    upd_cnt;
    logic             upd_disable;

    for (genvar c = 0; c < NCH; c++) begin : g_req
        logic vec_ok;
        assign vec_ok = (chans[c].vec < VEC_W'(NVEC));
        assign req[c] = idle && chans[c].en && vec_ok && pend[chans[c].vec];
    end

    udma_pend i_pend (
        .clk     (clk),
        .rst     (rst),
        .set_in  ({int_req, sw_start}),
        .clr_vld (gnt_vld),
        .clr_vec (chans[gnt_idx].vec),
        .pend    (pend)
    );

    udma_arbiter i_arb (
        .req     (req),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    udma_chan_file i_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_ch      (cfg_ch),
        .cfg_reg     (cfg_reg),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .upd_vld     (upd_vld),
        .upd_ch      (upd_ch),
        .upd_src     (upd_src),
        .upd_dst     (upd_dst),
        .upd_cnt     (upd_cnt),
        .upd_disable (upd_disable),
        .chans       (chans)
    );

    udma_xfer_seq i_seq (
        .clk         (clk),
        .rst         (rst),
        .chans       (chans),
        .gnt_vld     (gnt_vld),
        .gnt_idx     (gnt_idx),
        .idle        (idle),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_rdy     (bus_rdy),
        .upd_vld     (upd_vld),
        .upd_ch      (upd_ch),
        .upd_src     (upd_src),
        .upd_dst     (upd_dst),
        .upd_cnt     (upd_cnt),
        .upd_disable (upd_disable),
        .tc          (tc)
    );

    // R1
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && req[0]) |=> (upd_ch == '0));

endmodule

// File: tb/test_udma_engine.sv
module test_udma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [46:0] int_req = '0;
    logic        sw_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [2:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_req, bus_we;
    logic [23:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rdy = 1'b0;
    logic [7:0]  tc;

    udma_engine i_udma_engine (
        .clk(clk), .rst(rst), .int_req(int_req), .sw_start(sw_start),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .tc(tc)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // Memory model: 256 bytes, byte lanes follow address bits 1..0.
    logic [7:0]  mem [256];
    logic [7:0]  snap [256];
    logic [23:0] log_addr [16];
    int          nacc = 0;
    int          waits = 0;
    int          wcnt = 0;
    logic [7:0]  tc_seen = '0;

    assign bus_rdata = {mem[{bus_addr[7:2], 2'd3}], mem[{bus_addr[7:2], 2'd2}],
                        mem[{bus_addr[7:2], 2'd1}], mem[{bus_addr[7:2], 2'd0}]};

    always @(negedge clk) begin
        if (|tc) tc_seen = tc_seen | tc;
        if (bus_req) begin
            if (wcnt >= waits) begin
                bus_rdy = 1'b1;
                wcnt = 0;
                if (nacc < 16) log_addr[nacc] = bus_addr;
                nacc++;
                if (bus_we)
                    for (int k = 0; k < 4; k++)
                        if (bus_be[k]) mem[{bus_addr[7:2], k[1:0]}] = bus_wdata[8*k +: 8];
            end else begin
                bus_rdy = 1'b0;
                wcnt++;
            end
        end else begin
            bus_rdy = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int ch, input int r, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = ch[2:0]; cfg_reg = r[2:0]; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int ch, input int r, output logic [31:0] d);
        cfg_ch = ch[2:0]; cfg_reg = r[2:0];
        #1 d = cfg_rdata;
    endtask

    task automatic clear_obs();
        nacc = 0;
        tc_seen = '0;
    endtask

    // Source 0 is the software start, source v maps to int_req[v-1].
    task automatic fire(input int v);
        @(posedge clk); #1;
        if (v == 0) sw_start = 1'b1; else int_req[v-1] = 1'b1;
        @(posedge clk); #1;
        sw_start = 1'b0; int_req = '0;
        repeat (14) @(posedge clk);
        #2;
    endtask

    task automatic prog(input int ch, input int v, input logic [6:0] md,
                        input logic [31:0] s, input logic [31:0] d, input logic [15:0] n);
        cfg_wr(ch, 4, 32'(v));
        cfg_wr(ch, 3, 32'(md));
        cfg_wr(ch, 0, s);
        cfg_wr(ch, 1, d);
        cfg_wr(ch, 2, 32'(n));
    endtask

    function automatic logic [31:0] exp_next(logic [31:0] a, logic [1:0] u, int n);
        logic [23:0] lo;
        lo = a[23:0];
        if (u == 2'd1) lo = lo + 24'(n);
        else if (u == 2'd2) lo = lo - 24'(n);
        return {a[31:24], lo};
    endfunction

    typedef struct packed {
        logic [6:0]  mode;
        logic [31:0] src;
        logic [31:0] dst;
    } row_t;

    // mode = {count_only, dst step[5:4], src step[3:2], size[1:0]}
    localparam row_t TBL [6] = '{
        '{7'h14, 32'h0000_0011, 32'h0000_0042},
        '{7'h25, 32'h0000_0020, 32'h0000_0056},
        '{7'h12, 32'h1200_0030, 32'h0000_0080},
        '{7'h0A, 32'hAB00_0000, 32'h0000_00C0},
        '{7'h24, 32'h77FF_FFFF, 32'h0000_0001},
        '{7'h3D, 32'h0000_004A, 32'h0000_00A6}
    };

    initial begin
        #(190000 * 10);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] act, exp;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 13);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #3;

        // R11: reset state
        chk("R11 bus_req", 32'(bus_req), 0);
        chk("R11 tc", 32'(tc), 0);
        cfg_rd(3, 0, rd); chk("R11 src", rd, 0);
        cfg_rd(0, 2, rd); chk("R11 cnt", rd, 0);
        clear_obs();
        fire(40);
        chk("R11 disabled no access", 32'(nacc), 0);

        // Table walk: R4 R5 R3 R9 R6 R8 R12
        for (int i = 0; i < 6; i++) begin
            int n;
            logic [1:0] sz;
            sz = TBL[i].mode[1:0];
            n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 13 + i);
            prog(i, i + 10, TBL[i].mode, TBL[i].src, TBL[i].dst, 16'd5);
            cfg_rd(i, 3, rd); chk("R12 mode readback", rd, 32'(TBL[i].mode));
            for (int k = 0; k < 256; k++) snap[k] = mem[k];
            clear_obs();
            fire(i + 10);
            act = '0; exp = '0;
            for (int k = 0; k < n; k++) begin
                act[8*k +: 8] = mem[8'(TBL[i].dst[7:0] + 8'(k))];
                exp[8*k +: 8] = snap[8'(TBL[i].src[7:0] + 8'(k))];
            end
            chk($sformatf("R9 R4 data row %0d", i), act, exp);
            chk($sformatf("R4 lane below row %0d", i),
                32'(mem[8'(TBL[i].dst[7:0] - 8'd1)]), 32'(snap[8'(TBL[i].dst[7:0] - 8'd1)]));
            chk($sformatf("R4 lane above row %0d", i),
                32'(mem[8'(TBL[i].dst[7:0] + 8'(n))]), 32'(snap[8'(TBL[i].dst[7:0] + 8'(n))]));
            chk($sformatf("R3 bus addr row %0d", i), 32'(log_addr[0]), 32'(TBL[i].src[23:0]));
            chk($sformatf("R9 accesses row %0d", i), 32'(nacc), 2);
            cfg_rd(i, 0, rd);
            chk($sformatf("R5 R3 src row %0d", i), rd, exp_next(TBL[i].src, TBL[i].mode[3:2], n));
            cfg_rd(i, 1, rd);
            chk($sformatf("R5 dst row %0d", i), rd, exp_next(TBL[i].dst, TBL[i].mode[5:4], n));
            cfg_rd(i, 2, rd);
            chk($sformatf("R6 cnt row %0d", i), rd, 4);
            chk($sformatf("R7 no tc row %0d", i), 32'(tc_seen), 0);
        end

        // R1: two channels triggered together
        prog(2, 20, 7'h14, 32'h60, 32'h64, 16'd5);
        prog(5, 21, 7'h14, 32'h70, 32'h74, 16'd5);
        clear_obs();
        @(posedge clk); #1;
        int_req[19] = 1'b1; int_req[20] = 1'b1;
        @(posedge clk); #1;
        int_req = '0;
        repeat (16) @(posedge clk);
        #2;
        chk("R1 first read is channel 2", 32'(log_addr[0]), 32'h60);
        chk("R1 second service is channel 5", 32'(log_addr[2]), 32'h70);
        chk("R1 access count", 32'(nacc), 4);

        // R2: shared start source
        prog(1, 30, 7'h14, 32'h10, 32'h18, 16'd5);
        prog(3, 30, 7'h14, 32'h20, 32'h28, 16'd5);
        clear_obs();
        fire(30);
        cfg_rd(1, 2, rd); chk("R2 winner counted", rd, 4);
        cfg_rd(3, 2, rd); chk("R2 loser untouched", rd, 5);
        chk("R2 one service", 32'(nacc), 2);

        // R10 R6: count-only with counter zero
        prog(4, 31, 7'h44, 32'h0000_0100, 32'h0, 16'd0);
        clear_obs();
        fire(31);
        chk("R10 no bus access", 32'(nacc), 0);
        cfg_rd(4, 0, rd); chk("R10 src stepped", rd, 32'h101);
        cfg_rd(4, 2, rd); chk("R6 zero wraps", rd, 32'hFFFF);
        chk("R6 no tc on wrap", 32'(tc_seen), 0);

        // R7 R8: terminal count via software start
        prog(6, 0, 7'h14, 32'h10, 32'h90, 16'd2);
        clear_obs();
        fire(0);
        chk("R7 no tc first", 32'(tc_seen), 0);
        cfg_rd(6, 2, rd); chk("R7 cnt one", rd, 1);
        fire(0);
        chk("R7 tc pulse", 32'(tc_seen), 32'h40);
        cfg_rd(6, 2, rd); chk("R7 cnt zero", rd, 0);
        clear_obs();
        fire(0);
        chk("R7 disabled ignores trigger", 32'(nacc), 0);
        cfg_rd(6, 2, rd); chk("R7 cnt stays zero", rd, 0);
        cfg_wr(6, 2, 32'd1);
        repeat (12) @(posedge clk);
        #2;
        chk("R8 stale trigger served after rearm", 32'(nacc), 2);
        chk("R7 tc after rearm", 32'(tc_seen), 32'h40);

        // R9: wait states
        waits = 2;
        prog(7, 32, 7'h12, 32'h20, 32'hE0, 16'd3);
        for (int k = 0; k < 256; k++) snap[k] = mem[k];
        clear_obs();
        fire(32);
        chk("R9 wait data", {mem[8'hE3], mem[8'hE2], mem[8'hE1], mem[8'hE0]},
            {snap[8'h23], snap[8'h22], snap[8'h21], snap[8'h20]});
        chk("R9 wait accesses", 32'(nacc), 2);
        cfg_rd(7, 1, rd); chk("R5 wait dst", rd, 32'hE4);
        waits = 0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule